// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects level-sensitive interrupt requests from 96 or 128 sources and presents one of them at a time to a processor. The sources are grouped into banks of 32. Each bank has a mask, two write-only aliases that enable or disable individual sources, and a read-only view of which enabled sources are asserted. Every source has its own priority register. A global threshold filters out sources that are not urgent enough.

When no selection is held, the block picks the most urgent eligible source, latches its number and raises `irq_o`. The selection then stays frozen until software writes the acknowledge bit. One cycle later the block arbitrates again. A soft reset, started through the configuration register, returns the programmable state to its defaults over a fixed number of cycles. A status bit reports when the soft reset has finished.

The controller is a three-state machine. IDLE arbitrates on every cycle and moves to HOLD when an eligible source exists. HOLD keeps the latched number and returns to IDLE on an acknowledge write. SRST is entered from IDLE or HOLD by a soft-reset write and goes back to IDLE after `SRST_CYC` cycles. The soft-reset transition takes priority over the other two.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After hardware reset, `irq_o` is 0. Every bank mask reads 0xFFFFFFFF. The threshold (0x68) reads 0xFF. Status (0x14) bit 0 reads 1. The active register (0x40) reads 0. Config (0x10) reads 0.
- R2: Bank n's mask reads at 0x84+n*0x20, where a 1 bit means the source is disabled. Writing 1s to the clear alias at 0x88+n*0x20 enables those sources. Zero bits in that write leave the mask unchanged.
- R3: Writing 1s to the set alias at 0x8C+n*0x20 disables those sources. Zero bits in that write leave the mask unchanged.
- R4: Bank n's pending register at 0x98+n*0x20 reads, bit for bit, the source inputs ANDed with the inverted mask.
- R5: Source i's level register is at 0x100+4*i. It stores a 6-bit priority in bits [7:2], and all other bits read 0.
- R6: In IDLE the block selects, among asserted unmasked sources, the one with the lowest priority value. On a tie the lowest source number wins. `irq_o` rises one cycle after such a source is present, and 0x40 bits [6:0] then read its number.
- R7: A source is eligible only if its priority value is below the threshold. A threshold of 0xFF disables this check.
- R8: While `irq_o` is high, the selection and `irq_o` stay unchanged until an acknowledge write. A control write with bit 0 clear has no effect.
- R9: Writing 1 to bit 0 of the control register (0x48) in HOLD drops `irq_o` and clears 0x40 on the next cycle. Arbitration runs on the cycle after that.
- R10: Writing 1 to config bit 1 starts a soft reset. During the soft reset, status bit 0 reads 0 and config bit 1 reads 1 for `SRST_CYC` cycles, `irq_o` stays low, and other writes are ignored. Afterwards all masks are 1, all levels are 0, the threshold is 0xFF and the selection is clear. Config bit 0 (autoidle) is read/write and keeps the value written.
- R11: 0x00 reads the major revision in bits [7:4] and the minor revision in bits [3:0]. Unmapped addresses read 0.
- R12: Arbitration in a cycle uses the register values held before that cycle's write. A mask write that lands on the arbitration edge does not stop that selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level interrupt requests |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
Two functions can fall on the same clock edge: the re-arbitration that follows an acknowledge, and a register write that changes the mask of the source about to win. The bench provokes this by issuing a mask-set write for the most urgent source in the cycle directly after the acknowledge. It then judges, against a behavioural model that always uses pre-edge state, that this source is still selected and that its mask bit is set afterwards. A second collision occurs when a soft reset is issued while a selection is held. Here `irq_o` must drop at once and the reset must win over both HOLD and arbitration.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ADDR_W    = 12;
    localparam int BANK_SRC  = 32;
    localparam int BANK_STEP = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_SRST = 2'd2
    } ctl_state_e;

    localparam logic [ADDR_W-1:0] OFS_REV   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_ACT   = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_THR   = 12'h068;
    localparam logic [ADDR_W-1:0] OFS_BANK0 = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_LVL   = 12'h100;

    // offsets inside one bank window
    localparam logic [4:0] SUB_MASK = 5'h04;
    localparam logic [4:0] SUB_CLR  = 5'h08;
    localparam logic [4:0] SUB_SET  = 5'h0C;
    localparam logic [4:0] SUB_PEND = 5'h18;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wbits,
    input  logic [W-1:0] src,
    output logic [W-1:0] mask,
    output logic [W-1:0] pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (clr_all) begin
            mask <= '1;
        end else if (set_we) begin
            mask <= mask | wbits;
        end else if (clr_we) begin
            mask <= mask & ~wbits;
        end
    end

    assign pend = src & ~mask;
endmodule

// File: rtl/irq_level_regs.sv
module irq_level_regs #(
    parameter int N  = 96,
    parameter int PW = 6,
    parameter int IW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_all,
    input  logic                 we,
    input  logic [IW-1:0]        widx,
    input  logic [PW-1:0]        wpri,
    output logic [N-1:0][PW-1:0] pri
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri <= '0;
        end else if (clr_all) begin
            pri <= '0;
        end else if (we) begin
            for (int i = 0; i < N; i++) begin
                if (widx == IW'(i)) pri[i] <= wpri;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N  = 96,
    parameter int PW = 6,
    parameter int IW = 7
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][PW-1:0] pri,
    input  logic [7:0]           thr,
    output logic                 valid,
    output logic [IW-1:0]        idx
);
    logic [PW-1:0] best;
    logic          thr_off;

    assign thr_off = (thr == 8'hFF);

    // ascending scan with strict compare: ties keep the lower number
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (thr_off || (8'(pri[i]) < thr)) &&
                (!valid || (pri[i] < best))) begin
                valid = 1'b1;
                best  = pri[i];
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC   = 96,
    parameter int REV_MAJOR = 4,
    parameter int REV_MINOR = 0,
    parameter int SRST_CYC  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               irq_o
);
    localparam int NB  = NUM_SRC / BANK_SRC;
    localparam int IW  = $clog2(NUM_SRC);
    localparam int PW  = 6;
    localparam int CW  = $clog2(SRST_CYC + 1);
    localparam int BSW = ADDR_W - 5;
    localparam logic [ADDR_W-1:0] BANK_END = ADDR_W'(int'(OFS_BANK0) + BANK_STEP * NB);
    localparam logic [ADDR_W-1:0] LVL_END  = ADDR_W'(int'(OFS_LVL) + 4 * NUM_SRC);

    ctl_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] sel_q;
    logic [7:0]    thr_q;
    logic          auto_q;
    logic          srst_busy;
    logic          we_ok, soft_wr, ack_wr;

    logic [ADDR_W-1:0] bank_off, lvl_off;
    logic              in_bank, hit_lvl;
    logic [BSW-1:0]    bank_sel;
    logic [4:0]        sub;
    logic [IW-1:0]     lvl_idx;

    logic [NB-1:0][31:0]         mask_all, pend_all;
    logic [NUM_SRC-1:0]          pend_flat;
    logic [NUM_SRC-1:0][PW-1:0]  pri;
    logic                        win_valid;
    logic [IW-1:0]               win_idx;
    logic [31:0]                 rdata_c;

    // ---------------- address decode ----------------
    assign bank_off = addr - OFS_BANK0;
    assign lvl_off  = addr - OFS_LVL;
    assign in_bank  = (addr >= OFS_BANK0) && (addr < BANK_END);
    assign hit_lvl  = (addr >= OFS_LVL) && (addr < LVL_END) && (addr[1:0] == 2'b00);
    assign bank_sel = bank_off[ADDR_W-1:5];
    assign sub      = bank_off[4:0];
    assign lvl_idx  = lvl_off[IW+1:2];

    assign we_ok   = wr_en && (st_q != ST_SRST);
    assign soft_wr = we_ok && (addr == OFS_CFG) && wdata[1];
    assign ack_wr  = we_ok && (addr == OFS_CTRL) && wdata[0] && (st_q == ST_HOLD);

    // ---------------- banks ----------------
    for (genvar b = 0; b < NB; b++) begin : g_bank
        irq_mask_bank #(.W(BANK_SRC)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_all (srst_busy),
            .set_we  (we_ok && in_bank && (bank_sel == BSW'(b)) && (sub == SUB_SET)),
            .clr_we  (we_ok && in_bank && (bank_sel == BSW'(b)) && (sub == SUB_CLR)),
            .wbits   (wdata),
            .src     (src_i[b*BANK_SRC +: BANK_SRC]),
            .mask    (mask_all[b]),
            .pend    (pend_all[b])
        );
        assign pend_flat[b*BANK_SRC +: BANK_SRC] = pend_all[b];
    end

    irq_level_regs #(.N(NUM_SRC), .PW(PW), .IW(IW)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (srst_busy),
        .we      (we_ok && hit_lvl),
        .widx    (lvl_idx),
        .wpri    (wdata[7:2]),
        .pri     (pri)
    );

    irq_arbiter #(.N(NUM_SRC), .PW(PW), .IW(IW)) u_arb (
        .req   (pend_flat),
        .pri   (pri),
        .thr   (thr_q),
        .valid (win_valid),
        .idx   (win_idx)
    );

    // ---------------- state machine ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (soft_wr)        st_d = ST_SRST;
                else if (win_valid) st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (soft_wr)     st_d = ST_SRST;
                else if (ack_wr) st_d = ST_IDLE;
            end
            ST_SRST: begin
                if (cnt_q == CW'(SRST_CYC - 1)) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == ST_SRST) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        irq_o     = (st_q == ST_HOLD);
        srst_busy = (st_q == ST_SRST);
    end

    // ---------------- latched selection and scalar registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (soft_wr || srst_busy) begin
            sel_q <= '0;
        end else if ((st_q == ST_IDLE) && win_valid) begin
            sel_q <= win_idx;
        end else if (ack_wr) begin
            sel_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q  <= 8'hFF;
            auto_q <= 1'b0;
        end else if (srst_busy) begin
            thr_q  <= 8'hFF;
        end else if (we_ok) begin
            if (addr == OFS_THR) thr_q  <= wdata[7:0];
            if (addr == OFS_CFG) auto_q <= wdata[0];
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        rdata_c = '0;
        case (addr)
            OFS_REV:  rdata_c[7:0]    = {4'(REV_MAJOR), 4'(REV_MINOR)};
            OFS_CFG:  rdata_c[1:0]    = {srst_busy, auto_q};
            OFS_STAT: rdata_c[0]      = ~srst_busy;
            OFS_ACT:  rdata_c[IW-1:0] = sel_q;
            OFS_THR:  rdata_c[7:0]    = thr_q;
            default:  rdata_c         = '0;
        endcase
        for (int b = 0; b < NB; b++) begin
            if (in_bank && (bank_sel == BSW'(b))) begin
                if (sub == SUB_MASK)      rdata_c = mask_all[b];
                else if (sub == SUB_PEND) rdata_c = pend_all[b];
            end
        end
        if (hit_lvl) rdata_c = {24'b0, pri[lvl_idx], 2'b00};
    end

    assign rdata = rd_en ? rdata_c : 32'b0;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int IW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [11:0]   addr,
    input logic [31:0]   wdata,
    input logic          irq_o,
    input logic          busy,
    input logic [IW-1:0] sel_q,
    input logic          win_valid,
    input logic [31:0]   mask0
);
    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && wr_en && addr == 12'h048 && wdata[0]) |=> !irq_o);

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_en && (addr == 12'h048 || addr == 12'h010)))
        |=> (irq_o && $stable(sel_q)));

    // R10
    srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_o);

    // R10
    srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && addr == 12'h010 && wdata[1]) |=> busy);

    // R6
    rise_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(win_valid));

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && addr == 12'h08C)
        |=> ((mask0 & $past(wdata)) == $past(wdata)));
endmodule

bind lvl_irq_ctrl irq_ctrl_chk #(.IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq_o     (irq_o),
    .busy      (srst_busy),
    .sel_q     (sel_q),
    .win_valid (win_valid),
    .mask0     (mask_all[0])
);

// File: tb/sim_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module sim_lvl_irq_ctrl;
    localparam int NUM  = 96;
    localparam int NB   = NUM / 32;
    localparam int SRST = 4;
    localparam int MAJ  = 4;
    localparam int MIN  = 0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NUM-1:0]  src = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq_o;

    int checks = 0;
    int failures = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lvl_irq_ctrl #(.NUM_SRC(NUM), .REV_MAJOR(MAJ), .REV_MINOR(MIN), .SRST_CYC(SRST)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_mask [NB];
    int          m_pri  [NUM];
    int          m_thr;
    bit          m_hold, m_busy, m_auto;
    int          m_sel, m_cnt;

    function automatic int m_winner();
        int best = -1;
        for (int i = 0; i < NUM; i++) begin
            if (src[i] && !m_mask[i/32][i%32] && (m_thr == 255 || m_pri[i] < m_thr)) begin
                if (best < 0 || m_pri[i] < m_pri[best]) best = i;
            end
        end
        return best;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] pnd;
        if (a == 'h000) return 32'(MAJ * 16 + MIN);
        if (a == 'h010) return {30'b0, m_busy, m_auto};
        if (a == 'h014) return {31'b0, !m_busy};
        if (a == 'h040) return 32'(m_sel);
        if (a == 'h068) return 32'(m_thr);
        if (a >= 'h080 && a < 'h080 + 32 * NB) begin
            if ((a - 'h080) % 32 == 4) return m_mask[(a - 'h080) / 32];
            if ((a - 'h080) % 32 == 24) begin
                pnd = src[((a - 'h080) / 32) * 32 +: 32] & ~m_mask[(a - 'h080) / 32];
                return pnd;
            end
            return 32'b0;
        end
        if (a >= 'h100 && a < 'h100 + 4 * NUM && a % 4 == 0) return 32'(m_pri[(a - 'h100) / 4] * 4);
        return 32'b0;
    endfunction

    task automatic m_clear();
        for (int b = 0; b < NB; b++) m_mask[b] = '1;
        for (int i = 0; i < NUM; i++) m_pri[i] = 0;
        m_thr = 255;
    endtask

    always @(posedge clk) begin
        int w;
        int a;
        if (!rst_n) begin
            m_clear();
            m_hold = 0; m_sel = 0; m_busy = 0; m_cnt = 0; m_auto = 0;
        end else begin
            w = m_winner();
            a = int'(addr);
            if (m_busy) begin
                m_clear();
                m_hold = 0; m_sel = 0;
                if (m_cnt == SRST - 1) m_busy = 0; else m_cnt++;
            end else begin
                if (wr_en && a == 'h010 && wdata[1]) begin
                    m_busy = 1; m_cnt = 0; m_hold = 0; m_sel = 0;
                end else if (!m_hold && w >= 0) begin
                    m_hold = 1; m_sel = w;
                end else if (m_hold && wr_en && a == 'h048 && wdata[0]) begin
                    m_hold = 0; m_sel = 0;
                end
                if (wr_en) begin
                    if (a == 'h010) m_auto = wdata[0];
                    if (a == 'h068) m_thr = int'(wdata[7:0]);
                    if (a >= 'h080 && a < 'h080 + 32 * NB) begin
                        if ((a - 'h080) % 32 == 8)  m_mask[(a - 'h080) / 32] &= ~wdata;
                        if ((a - 'h080) % 32 == 12) m_mask[(a - 'h080) / 32] |= wdata;
                    end
                    if (a >= 'h100 && a < 'h100 + 4 * NUM && a % 4 == 0)
                        m_pri[(a - 'h100) / 4] = int'(wdata[7:2]);
                end
            end
        end
    end

    // per-cycle comparison of the interrupt line (R6, R8, R9, R10)
    always @(negedge clk) begin
        if (run && !done) begin
            checks++;
            if (irq_o !== m_hold) begin
                failures++;
                $display("FAIL R8 irq_o cycle compare: actual=%0b expected=%0b at %0t", irq_o, m_hold, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = 12'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, input string tag);
        logic [31:0] exp;
        rd_en = 1'b1; addr = 12'(a);
        #1;
        exp = m_read(a);
        checks++;
        if (rdata !== exp) begin
            failures++;
            $display("FAIL %s read 0x%03h: actual=0x%08h expected=0x%08h", tag, a, rdata, exp);
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- scenario ----------------
    initial begin
        tick(3);
        rst_n = 1'b1;
        run = 1'b1;
        tick(1);

        // R1 reset state, R11 revision and unmapped
        rd('h000, "R11");
        rd('h020, "R11");
        rd('h084, "R1"); rd('h0A4, "R1"); rd('h0C4, "R1");
        rd('h068, "R1"); rd('h014, "R1"); rd('h040, "R1"); rd('h010, "R1");

        // R2 clear alias, zero write no effect
        wr('h088, 32'h0000_0028);
        rd('h084, "R2");
        wr('h088, 32'h0);
        rd('h084, "R2");
        // R3 set alias
        wr('h08C, 32'h0000_0020);
        rd('h084, "R3");

        // R5 level registers
        wr('h100 + 4 * 3, 32'(10 << 2));
        wr('h100 + 4 * 5, 32'hFFFF_FFFF);
        rd('h100 + 4 * 3, "R5");
        rd('h100 + 4 * 5, "R5");

        // R4 pending with masked and unmasked sources
        src[3] = 1'b1; src[5] = 1'b1; src[40] = 1'b1;
        rd('h098, "R4");
        rd('h0B8, "R4");
        tick(2);
        rd('h040, "R6");

        // R8 frozen selection while a more urgent source appears
        wr('h0C8, 32'(1 << 6));
        wr('h100 + 4 * 70, 32'(2 << 2));
        src[70] = 1'b1;
        tick(3);
        rd('h040, "R8");
        wr('h048, 32'h0);
        rd('h040, "R8");

        // R9 acknowledge then re-arbitration
        wr('h048, 32'h1);
        rd('h040, "R9");
        rd('h040, "R9");

        // R6 tie on priority resolved by lowest number
        src[70] = 1'b0;
        wr('h0C8, 32'(1 << 7));
        wr('h100 + 4 * 71, 32'(10 << 2));
        src[71] = 1'b1;
        wr('h048, 32'h1);
        tick(2);
        rd('h040, "R6");

        // R7 threshold filtering and disable value
        wr('h068, 32'd10);
        wr('h048, 32'h1);
        tick(2);
        rd('h040, "R7");
        src[70] = 1'b1;
        tick(2);
        rd('h040, "R7");
        wr('h048, 32'h1);
        wr('h068, 32'hFF);
        tick(2);
        rd('h040, "R7");

        // R12 mask-set write on the arbitration edge after an acknowledge
        wr('h048, 32'h1);
        wr('h0CC, 32'(1 << 6));
        rd('h040, "R12");
        rd('h0C4, "R12");
        wr('h048, 32'h1);
        tick(2);
        rd('h040, "R12");

        // R10 soft reset while a selection is held
        wr('h010, 32'h3);
        rd('h014, "R10");
        rd('h010, "R10");
        wr('h068, 32'h5);
        tick(SRST + 2);
        rd('h014, "R10");
        rd('h068, "R10");
        rd('h084, "R10");
        rd('h0C4, "R10");
        rd('h100 + 4 * 3, "R10");
        rd('h040, "R10");
        rd('h010, "R10");
        tick(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule